// File: doc/BRIEF.md
# Register List Run Expander

This block accepts a 32-bit instruction word whose register-list field is spread over several bit positions. It maps each field bit to a general register and builds a 32-bit register mask. It then walks that mask from register 0 upward and emits one descriptor for each maximal run of adjacent selected registers. A descriptor gives the lowest and the highest register of the run.

The word comes in on a valid/ready input. The descriptors leave on a valid/ready output at a rate of at most one per cycle, and the final one carries a last flag. A one-cycle done pulse closes every operation, including one whose list is empty. The expanded mask and an error flag are registered outputs. The error flag covers a field bit that has no register assigned. Both stay stable from the cycle after acceptance until the next word is accepted.

Top module: `reglist_runs`

## Requirements
- R1: With the default field mask 0xFFE00001, only word bits 31..21 and bit 0 take part; bits 20..1 have no effect on any output.
- R2: The field bits select registers as follows: bit 0 selects register 30, bit 21 selects 31, bit 22 selects 29, bit 23 selects 28, bits 24..27 select 23, 22, 21, 20, and bits 28..31 select 27, 26, 25, 24; bit n of mask_o is register n.
- R3: Descriptors come out in ascending register order whatever the order of the field bits, and each new run starts at least two registers above the end of the previous one.
- R4: Every maximal run of adjacent set registers gives exactly one descriptor with run_lo_o <= run_hi_o; a lone register gives run_lo_o equal to run_hi_o.
- R5: A word that selects no register produces no descriptor, and done_o is high in the cycle after acceptance.
- R6: A set field bit that has no register assigned (possible when FIELD_MASK is widened) raises err_o for the operation, while the mapped bits are still expanded.
- R7: A descriptor with out_valid_o high and out_ready_i low keeps out_valid_o and all descriptor fields unchanged in the next cycle.
- R8: The last descriptor has run_last_o high, the others low, and done_o pulses for one cycle in the cycle after the last descriptor is taken.
- R9: in_ready_o is low from acceptance until the cycle after done_o; in_valid_i and in_word_i are ignored while it is low.
- R10: While rst_ni is low, in_ready_o is high and out_valid_o, done_o, err_o and mask_o are zero.
- R11: mask_o and err_o load only when a word is accepted and hold until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction word offered |
| in_ready_o | output | 1 | Block idle, word can be taken |
| in_word_i | input | 32 | Instruction word |
| out_valid_o | output | 1 | Run descriptor present |
| out_ready_i | input | 1 | Consumer takes the descriptor |
| run_lo_o | output | 5 | Lowest register of the run |
| run_hi_o | output | 5 | Highest register of the run |
| run_last_o | output | 1 | Final descriptor of the operation |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| mask_o | output | 32 | Expanded register mask |
| err_o | output | 1 | Unmapped field bit seen |

## Verification
A bad expansion shows up on mask_o in the first cycle after acceptance. The first descriptor then shows the same fault. A corrupted remainder register shows one handshake later, as a run that is missing, repeated, split or out of order on run_lo_o and run_hi_o. A wrong busy or end state shows as done_o or in_ready_o moving one cycle early or late. The reference model compares every port on every cycle, under steady, alternating and irregular back-pressure, so each of these faults is caught in the cycle where it first reaches a port.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_N  = 32;
  localparam int unsigned REG_W  = $clog2(REG_N);

  typedef struct packed {
    logic             ok;
    logic [REG_W-1:0] idx;
  } map_t;

  // field bit -> register; ok=0 for bits with no register
  function automatic map_t map_bit(input int unsigned b);
    map_t m;
    m.ok  = 1'b1;
    m.idx = '0;
    case (b)
      0:  m.idx = REG_W'(30);
      21: m.idx = REG_W'(31);
      22: m.idx = REG_W'(29);
      23: m.idx = REG_W'(28);
      24: m.idx = REG_W'(23);
      25: m.idx = REG_W'(22);
      26: m.idx = REG_W'(21);
      27: m.idx = REG_W'(20);
      28: m.idx = REG_W'(27);
      29: m.idx = REG_W'(26);
      30: m.idx = REG_W'(25);
      31: m.idx = REG_W'(24);
      default: m.ok = 1'b0;
    endcase
    return m;
  endfunction

  function automatic logic [REG_W-1:0] low_index(input logic [REG_N-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = REG_N - 1; i >= 0; i--)
      if (v[i]) r = REG_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/rl_expand.sv
module rl_expand
  import rl_pkg::*;
#(
  parameter logic [WORD_W-1:0] FIELD_MASK = 32'hFFE0_0001
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [REG_N-1:0]  mask_o,
  output logic              err_o
);
  always_comb begin
    mask_o = '0;
    err_o  = 1'b0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      if (FIELD_MASK[i] && word_i[i]) begin
        if (map_bit(i).ok) mask_o[map_bit(i).idx] = 1'b1;
        else               err_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rl_run_find.sv
module rl_run_find
  import rl_pkg::*;
(
  input  logic [REG_N-1:0] rem_i,
  output logic [REG_W-1:0] lo_o,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_N-1:0] rem_next_o,
  output logic             final_o
);
  logic [REG_N-1:0] below;   // bits under the lowest set bit
  logic [REG_N-1:0] filled;  // remainder with the bits below filled in
  logic [REG_N-1:0] gap;     // lowest zero of filled, one-hot
  logic [REG_N-1:0] run;

  always_comb begin
    below      = (rem_i & (~rem_i + 1'b1)) - 1'b1;
    filled     = rem_i | below;
    gap        = ~filled & (filled + 1'b1);
    run        = (gap - 1'b1) & ~below;
    lo_o       = low_index(rem_i);
    hi_o       = (gap == '0) ? REG_W'(REG_N - 1) : REG_W'(low_index(gap) - 1'b1);
    rem_next_o = rem_i & ~run;
    final_o    = (rem_next_o == '0);
  end
endmodule

// File: rtl/reglist_runs.sv
module reglist_runs
  import rl_pkg::*;
#(
  parameter logic [WORD_W-1:0] FIELD_MASK = 32'hFFE0_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [REG_W-1:0]  run_lo_o,
  output logic [REG_W-1:0]  run_hi_o,
  output logic              run_last_o,
  output logic              done_o,
  output logic [REG_N-1:0]  mask_o,
  output logic              err_o
);
  logic             busy_q;
  logic [REG_N-1:0] rem_q, mask_q;
  logic             err_q;
  logic [REG_N-1:0] exp_mask, rem_next;
  logic             exp_err, accept, take;

  rl_expand #(.FIELD_MASK(FIELD_MASK)) u_expand (
    .word_i (in_word_i),
    .mask_o (exp_mask),
    .err_o  (exp_err)
  );

  rl_run_find u_find (
    .rem_i      (rem_q),
    .lo_o       (run_lo_o),
    .hi_o       (run_hi_o),
    .rem_next_o (rem_next),
    .final_o    (run_last_o)
  );

  assign in_ready_o  = ~busy_q;
  assign accept      = in_valid_i & in_ready_o;
  assign out_valid_o = busy_q & (rem_q != '0);
  assign done_o      = busy_q & (rem_q == '0);
  assign take        = out_valid_o & out_ready_i;
  assign mask_o      = mask_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      rem_q  <= exp_mask;
      mask_q <= exp_mask;
      err_q  <= exp_err;
    end else if (take) begin
      rem_q <= rem_next;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(run_lo_o)
      && $stable(run_hi_o) && $stable(run_last_o));

  p_ascend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !run_last_o |=> out_valid_o
      && ({1'b0, run_lo_o} > {1'b0, $past(run_hi_o)} + 1'b1));

  p_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> run_lo_o <= run_hi_o && mask_o[run_lo_o] && mask_o[run_hi_o]);

  p_done_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && run_last_o |=> done_o && !out_valid_o);

  p_mask_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> $stable(mask_o) && $stable(err_o));

  p_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && mask_o == '0 |-> done_o && !out_valid_o);
endmodule

// File: tb/sim_reglist_runs.sv
module sim_reglist_runs;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic        iv = 1'b0, ordy = 1'b0, sel = 1'b0;
  logic [31:0] word = '0;

  logic        ir0, ov0, last0, done0, err0, ir1, ov1, last1, done1, err1;
  logic [4:0]  lo0, hi0, lo1, hi1;
  logic [31:0] m0, m1;

  reglist_runs u0 (.clk_i(clk), .rst_ni(rst_ni), .in_valid_i(iv & ~sel), .in_ready_o(ir0),
    .in_word_i(word), .out_valid_o(ov0), .out_ready_i(ordy), .run_lo_o(lo0), .run_hi_o(hi0),
    .run_last_o(last0), .done_o(done0), .mask_o(m0), .err_o(err0));

  reglist_runs #(.FIELD_MASK(32'hFFE0_0003)) u1 (.clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(iv & sel), .in_ready_o(ir1), .in_word_i(word), .out_valid_o(ov1),
    .out_ready_i(ordy), .run_lo_o(lo1), .run_hi_o(hi1), .run_last_o(last1), .done_o(done1),
    .mask_o(m1), .err_o(err1));

  wire        o_ir   = sel ? ir1 : ir0;
  wire        o_ov   = sel ? ov1 : ov0;
  wire        o_last = sel ? last1 : last0;
  wire        o_done = sel ? done1 : done0;
  wire        o_err  = sel ? err1 : err0;
  wire [4:0]  o_lo   = sel ? lo1 : lo0;
  wire [4:0]  o_hi   = sel ? hi1 : hi0;
  wire [31:0] o_mask = sel ? m1 : m0;

  int checks = 0, fails = 0, cyc = 0;
  int map_tbl[32];
  int lfsr = 32'h1ACE5;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] w, input bit s, input int mode, input bit junk);
    logic [31:0] fmask, em;
    bit ee, rdy;
    int lo_q[$], hi_q[$];
    int n;
    fmask = s ? 32'hFFE0_0003 : 32'hFFE0_0001;
    em = '0; ee = 0;
    for (int b = 0; b < 32; b++)
      if (fmask[b] && w[b]) begin
        if (map_tbl[b] < 0) ee = 1; else em[map_tbl[b]] = 1'b1;
      end
    for (int r = 0; r < 32; r++)
      if (em[r] && (r == 0 || !em[r-1])) begin
        int e = r;
        while (e < 31 && em[e+1]) e++;
        lo_q.push_back(r); hi_q.push_back(e);
      end
    @(negedge clk);
    sel = s; iv = 1'b1; word = w;
    chk(o_ir == 1'b1, "R9 idle ready", o_ir, 1);
    @(posedge clk);
    @(negedge clk);
    iv = junk; word = ~w;
    n = 0;
    forever begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? n[0] : lfsr[3];
      ordy = rdy;
      n++;
      chk(o_mask == em, "R2 R1 mask", o_mask, em);
      chk(o_err == ee, "R6 err", o_err, ee);
      chk(o_ir == 1'b0, "R9 busy ready", o_ir, 0);
      if (lo_q.size() > 0) begin
        chk(o_ov == 1'b1, "R7 valid", o_ov, 1);
        chk(o_lo == 5'(lo_q[0]), "R3 R4 run lo", o_lo, lo_q[0]);
        chk(o_hi == 5'(hi_q[0]), "R4 run hi", o_hi, hi_q[0]);
        chk(o_last == (lo_q.size() == 1), "R8 last flag", o_last, lo_q.size() == 1);
        chk(o_done == 1'b0, "R8 early done", o_done, 0);
        @(posedge clk);
        if (rdy) begin void'(lo_q.pop_front()); void'(hi_q.pop_front()); end
        @(negedge clk);
      end else begin
        chk(o_ov == 1'b0, "R5 no descriptor", o_ov, 0);
        chk(o_done == 1'b1, "R5 R8 done", o_done, 1);
        @(posedge clk);
        @(negedge clk);
        iv = 1'b0;
        chk(o_done == 1'b0, "R8 done one cycle", o_done, 0);
        chk(o_ir == 1'b1, "R9 ready again", o_ir, 1);
        chk(o_mask == em, "R11 mask held", o_mask, em);
        break;
      end
    end
    ordy = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 32; b++) map_tbl[b] = -1;
    map_tbl[0] = 30; map_tbl[21] = 31; map_tbl[22] = 29; map_tbl[23] = 28;
    map_tbl[24] = 23; map_tbl[25] = 22; map_tbl[26] = 21; map_tbl[27] = 20;
    map_tbl[28] = 27; map_tbl[29] = 26; map_tbl[30] = 25; map_tbl[31] = 24;
    repeat (3) @(negedge clk);
    chk(ir0 == 1'b1 && ov0 == 1'b0 && done0 == 1'b0, "R10 reset handshake", {ir0, ov0, done0}, 3'b100);
    chk(m0 == '0 && err0 == 1'b0, "R10 reset mask", m0, 0);
    rst_ni = 1'b1;
    run_op(32'h0000_0000, 0, 0, 0);   // R5 empty
    run_op(32'h001F_FFFE, 0, 0, 1);   // R1 ignored bits only
    run_op(32'h0000_0001, 0, 1, 0);   // R4 single register
    run_op(32'hFFE0_0001, 0, 2, 1);   // R4 one run 20..31
    run_op(32'h0900_0000, 0, 1, 0);   // R3 bits 24,27 -> r23,r20
    run_op(32'h0060_0000, 0, 2, 0);   // R3 r29, r31
    run_op(32'hF000_0000, 0, 0, 0);   // R2 r24..r27
    run_op(32'h0020_0001, 0, 2, 1);   // R2 r30..r31
    run_op(32'h8A4F_F3E1, 0, 2, 0);   // R1 mixed with ignored bits
    run_op(32'h5550_AAAB, 0, 1, 1);   // R7 back-pressure
    run_op(32'h0000_0003, 1, 0, 0);   // R6 unmapped bit plus r30
    run_op(32'h0000_0002, 1, 2, 0);   // R6 unmapped only
    run_op(32'h0080_0000, 0, 0, 0);   // R11 after error op
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule